// File: doc/BRIEF.md
# DDR2 Command Decoder and Power/Burst Tracker

This block watches a DDR2 command bus on every rising clock edge and turns the levels of the clock-enable, chip-select, row strobe, column strobe, write enable, bank and address pins into one decoded command. The result comes with its bank, its row, column or mode-register opcode, and a flag for auto-precharge or all-banks. The block keeps the clock-enable level from the previous edge. It also keeps a three-way power state (active, power-down, self-refresh), because the same pin pattern means different things depending on how clock-enable moved between two edges.

Two kinds of protocol error are reported. The first is a command other than no-operation or deselect while clock-enable is low, or during the edge where it changes. The second is a read or write issued while an earlier four-beat burst still occupies the bus. The block is meant for the front end of a memory model or for a bus monitor on the controller side. Every result is registered and valid from the edge that samples the pins until the next edge.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: While rst_n is low, the outputs show cmd_code 0, bank 0, address 0, and all flags low, with pwr_state 0 (active). The stored previous clock-enable level is low.
- R2: The command codes are: 0 deselect, 1 no-op, 2 mode-register set, 3 refresh, 4 self-refresh entry, 5 self-refresh exit, 6 precharge one bank, 7 precharge all, 8 activate, 9 write, 10 write+autoprecharge, 11 read, 12 read+autoprecharge, 13 power-down entry, 14 power-down exit, 15 illegal.
- R3: With clock-enable high at both edges, decoding works as follows. Chip-select high is deselect, whatever the other pins are. With chip-select low, the (ras,cas,we) levels decode as: LLL mode-register set (bank = register select, address = opcode), LLH refresh, LHH activate (bank and row), and HHH no-op.
- R4: With clock-enable high at both edges, (ras,cas,we)=LHL is a precharge. With A10 low it is a single-bank precharge on the given bank. With A10 high it is a precharge of all banks, reported with bank 0 and cmd_ap_all high.
- R5: With clock-enable high at both edges, (ras,cas,we)=HLL is a write and HLH is a read. A10 high selects the auto-precharge variant and sets cmd_ap_all. cmd_addr carries the column, which is the address with A10 forced to 0.
- R6: In the active state, clock-enable high then low with no-op or deselect on the bus reports power-down entry and moves pwr_state to 1. A later edge with clock-enable high and no-op or deselect reports power-down exit and returns pwr_state to 0.
- R7: In the active state, clock-enable high then low with the refresh pattern reports self-refresh entry and moves pwr_state to 2. In self-refresh, any edge that sees clock-enable high with no-op or deselect reports self-refresh exit and returns pwr_state to 0. No low edge needs to have been clocked in between.
- R8: Code 15 with cmd_illegal high is reported, and pwr_state is left unchanged, in three cases: any pattern other than no-op or deselect while clock-enable is low; any such pattern on an edge where clock-enable changes (except self-refresh entry); and the (ras,cas,we)=HHL pattern. No-op or deselect while clock-enable stays low is reported as itself.
- R9: A read or write starts a burst that holds the bus for BURST_CYC edges. burst_busy is high for the following BURST_CYC-1 cycles. A read or write decoded while the burst is still in progress raises burst_err, keeps its command code, and does not restart the burst.
- R10: All outputs are registered. The decode of the pins sampled at one rising edge appears after that edge and holds until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address pins, A10 at A10_POS |
| cmd_code | output | 4 | Decoded command (R2 encoding) |
| cmd_bank | output | BA_W | Bank of the command, 0 if none |
| cmd_addr | output | ADDR_W | Row, column or opcode, 0 if none |
| cmd_ap_all | output | 1 | Auto-precharge or all-banks flag |
| cmd_illegal | output | 1 | Command illegal in the current power state |
| burst_err | output | 1 | Read/write issued inside a running burst |
| burst_busy | output | 1 | Burst still holds the bus |
| pwr_state | output | 2 | 0 active, 1 power-down, 2 self-refresh |

## Verification
Each decoded field, both error flags, the power state and burst_busy are due exactly one edge after the pins that cause them. The bench drives the pins on the falling edge and compares at the next falling edge, after the rising edge that sampled them, so each comparison lands in the middle of the cycle where the result is valid. The reference model moves its own previous clock-enable level, power state and burst counter forward in that same step. A back-to-back read, a read one gap later, and the transitions into and out of each power state therefore land on exactly the cycle where the design must change.

// File: rtl/ddr2_cmd_pkg.sv
package ddr2_cmd_pkg;

   typedef enum logic [3:0] {
      CMD_DESEL = 4'd0,  CMD_NOP  = 4'd1,  CMD_MRS  = 4'd2,  CMD_REF  = 4'd3,
      CMD_SRE   = 4'd4,  CMD_SRX  = 4'd5,  CMD_PRE  = 4'd6,  CMD_PREA = 4'd7,
      CMD_ACT   = 4'd8,  CMD_WR   = 4'd9,  CMD_WRA  = 4'd10, CMD_RD   = 4'd11,
      CMD_RDA   = 4'd12, CMD_PDE  = 4'd13, CMD_PDX  = 4'd14, CMD_ILL  = 4'd15
   } cmd_e;

   typedef enum logic [1:0] {
      PS_ACTIVE = 2'd0,
      PS_PDN    = 2'd1,
      PS_SREF   = 2'd2
   } pwr_e;

   function automatic logic is_col(input cmd_e c);
      return (c == CMD_WR) || (c == CMD_WRA) || (c == CMD_RD) || (c == CMD_RDA);
   endfunction

   function automatic logic is_idle(input cmd_e c);
      return (c == CMD_DESEL) || (c == CMD_NOP);
   endfunction

endpackage

// File: rtl/ddr2_pin_decode.sv
module ddr2_pin_decode
   import ddr2_cmd_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic a10,
   output cmd_e pat
);
   always_comb begin
      unique casez ({cs_n, ras_n, cas_n, we_n})
         4'b1???: pat = CMD_DESEL;
         4'b0111: pat = CMD_NOP;
         4'b0000: pat = CMD_MRS;
         4'b0001: pat = CMD_REF;
         4'b0010: pat = a10 ? CMD_PREA : CMD_PRE;
         4'b0011: pat = CMD_ACT;
         4'b0100: pat = a10 ? CMD_WRA : CMD_WR;
         4'b0101: pat = a10 ? CMD_RDA : CMD_RD;
         default: pat = CMD_ILL;
      endcase
   end
endmodule

// File: rtl/ddr2_pwr_ctl.sv
module ddr2_pwr_ctl
   import ddr2_cmd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  cmd_e pat,
   output cmd_e code,
   output pwr_e state
);
   logic cke_q;
   pwr_e nstate;
   logic idle;

   assign idle = is_idle(pat);

   always_comb begin
      nstate = state;
      code   = pat;
      unique case (state)
         PS_SREF: begin
            if (cke) begin
               if (idle) begin
                  code   = CMD_SRX;
                  nstate = PS_ACTIVE;
               end else begin
                  code = CMD_ILL;
               end
            end else if (!idle) begin
               code = CMD_ILL;
            end
         end
         PS_PDN: begin
            if (cke) begin
               if (idle) begin
                  code   = CMD_PDX;
                  nstate = PS_ACTIVE;
               end else begin
                  code = CMD_ILL;
               end
            end else if (!idle) begin
               code = CMD_ILL;
            end
         end
         default: begin
            if (cke_q && cke) begin
               code = pat;
            end else if (cke_q && !cke) begin
               if (idle) begin
                  code   = CMD_PDE;
                  nstate = PS_PDN;
               end else if (pat == CMD_REF) begin
                  code   = CMD_SRE;
                  nstate = PS_SREF;
               end else begin
                  code = CMD_ILL;
               end
            end else if (!cke_q && cke) begin
               code = idle ? CMD_PDX : CMD_ILL;
            end else begin
               code = idle ? pat : CMD_ILL;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_q <= 1'b0;
         state <= PS_ACTIVE;
      end else begin
         cke_q <= cke;
         state <= nstate;
      end
   end
endmodule

// File: rtl/ddr2_burst_track.sv
module ddr2_burst_track #(
   parameter int BURST_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic col_cmd,
   output logic busy,
   output logic err
);
   localparam int CNT_W = (BURST_CYC > 2) ? $clog2(BURST_CYC) : 1;

   generate
      if (BURST_CYC > 1) begin : g_cnt
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(BURST_CYC - 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (col_cmd && (cnt == '0)) begin
               cnt <= LOAD;
            end else if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end
         end
         assign busy = (cnt != '0);
      end else begin : g_none
         assign busy = 1'b0;
      end
   endgenerate

   assign err = col_cmd && busy;
endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
   import ddr2_cmd_pkg::*;
#(
   parameter int BA_W      = 3,
   parameter int ADDR_W    = 16,
   parameter int A10_POS   = 10,
   parameter int BURST_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   ba,
   input  logic [ADDR_W-1:0] addr,
   output logic [3:0]        cmd_code,
   output logic [BA_W-1:0]   cmd_bank,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_ap_all,
   output logic              cmd_illegal,
   output logic              burst_err,
   output logic              burst_busy,
   output logic [1:0]        pwr_state
);
   localparam logic [ADDR_W-1:0] COL_MASK = ~(ADDR_W'(1) << A10_POS);

   generate
      if (A10_POS >= ADDR_W) begin : g_bad_a10
         $error("A10_POS must lie inside the address bus");
      end
      if (BA_W < 1 || BURST_CYC < 1) begin : g_bad_w
         $error("BA_W and BURST_CYC must be at least 1");
      end
   endgenerate

   cmd_e pat, code;
   pwr_e pstate;
   logic col_cmd, berr;
   logic [BA_W-1:0]   bank_d;
   logic [ADDR_W-1:0] addr_d;
   logic              flag_d;

   ddr2_pin_decode u_dec (
      .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .a10  (addr[A10_POS]), .pat(pat)
   );

   ddr2_pwr_ctl u_pwr (
      .clk(clk), .rst_n(rst_n), .cke(cke), .pat(pat), .code(code), .state(pstate)
   );

   assign col_cmd = is_col(code);

   ddr2_burst_track #(.BURST_CYC(BURST_CYC)) u_burst (
      .clk(clk), .rst_n(rst_n), .col_cmd(col_cmd), .busy(burst_busy), .err(berr)
   );

   always_comb begin
      bank_d = '0;
      addr_d = '0;
      flag_d = 1'b0;
      unique case (code)
         CMD_MRS, CMD_ACT: begin
            bank_d = ba;
            addr_d = addr;
         end
         CMD_PRE: bank_d = ba;
         CMD_PREA: flag_d = 1'b1;
         CMD_WR, CMD_RD: begin
            bank_d = ba;
            addr_d = addr & COL_MASK;
         end
         CMD_WRA, CMD_RDA: begin
            bank_d = ba;
            addr_d = addr & COL_MASK;
            flag_d = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_code    <= CMD_DESEL;
         cmd_bank    <= '0;
         cmd_addr    <= '0;
         cmd_ap_all  <= 1'b0;
         cmd_illegal <= 1'b0;
         burst_err   <= 1'b0;
      end else begin
         cmd_code    <= code;
         cmd_bank    <= bank_d;
         cmd_addr    <= addr_d;
         cmd_ap_all  <= flag_d;
         cmd_illegal <= (code == CMD_ILL);
         burst_err   <= berr;
      end
   end

   assign pwr_state = pstate;
endmodule

// File: rtl/ddr2_cmd_tracker_chk.sv
module ddr2_cmd_tracker_chk #(
   parameter int BA_W   = 3,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        cmd_code,
   input logic [BA_W-1:0]   cmd_bank,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              cmd_illegal,
   input logic              burst_err,
   input logic              burst_busy,
   input logic [1:0]        pwr_state
);
   // R2
   state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state != 2'd3);

   // R8
   illegal_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_illegal |-> (pwr_state == $past(pwr_state)));

   // R9
   burst_err_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_err |-> $past(burst_busy));

   // R9
   burst_err_on_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_err |-> (cmd_code >= 4'd9 && cmd_code <= 4'd12));

   // R7
   sref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_state) == 2'd0 && pwr_state == 2'd2) |-> (cmd_code == 4'd4));

   // R6
   pdn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_state) == 2'd1 && pwr_state == 2'd0) |-> (cmd_code == 4'd14));

   // R8
   low_power_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state != 2'd0) |-> (cmd_code <= 4'd1 || cmd_code == 4'd4 ||
                               cmd_code == 4'd13 || cmd_code == 4'd15));
endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(.BA_W(BA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
   .cmd_addr(cmd_addr), .cmd_illegal(cmd_illegal), .burst_err(burst_err),
   .burst_busy(burst_busy), .pwr_state(pwr_state)
);

// File: tb/ddr2_cmd_tracker_tb.sv
module ddr2_cmd_tracker_tb_top;
   localparam int BA_W = 3, ADDR_W = 16, A10 = 10, BC = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [BA_W-1:0] ba = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic [3:0] cmd_code;
   logic [BA_W-1:0] cmd_bank;
   logic [ADDR_W-1:0] cmd_addr;
   logic cmd_ap_all, cmd_illegal, burst_err, burst_busy;
   logic [1:0] pwr_state;

   int compared = 0, mismatched = 0;
   int m_prev = 0, m_state = 0, m_cnt = 0;

   always #10 clk = ~clk;

   ddr2_cmd_tracker #(.BA_W(BA_W), .ADDR_W(ADDR_W), .A10_POS(A10), .BURST_CYC(BC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .cmd_ap_all(cmd_ap_all), .cmd_illegal(cmd_illegal),
      .burst_err(burst_err), .burst_busy(burst_busy), .pwr_state(pwr_state)
   );

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag, input int c, input int b, input int a,
                            input int f, input int il, input int be, input int bb, input int ps);
      cmp(tag, "code", cmd_code, c);
      cmp(tag, "bank", cmd_bank, b);
      cmp(tag, "addr", cmd_addr, a);
      cmp(tag, "ap_all", cmd_ap_all, f);
      cmp(tag, "illegal", cmd_illegal, il);
      cmp(tag, "burst_err", burst_err, be);
      cmp(tag, "burst_busy", burst_busy, bb);
      cmp(tag, "pwr_state", pwr_state, ps);
   endtask

   // Behavioural reference: pattern name from the pin levels, then the power rules.
   task automatic step(input string tag, input bit k, input bit cs, input bit r,
                       input bit c, input bit w, input int b, input int a);
      int pat, code, eb, ea, ef, col, err, nst;
      bit a10, idle;
      cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
      ba = b[BA_W-1:0]; addr = a[ADDR_W-1:0];
      a10 = a[A10];
      if (cs) pat = 0;
      else if ({r, c, w} == 3'b111) pat = 1;
      else if ({r, c, w} == 3'b000) pat = 2;
      else if ({r, c, w} == 3'b001) pat = 3;
      else if ({r, c, w} == 3'b010) pat = a10 ? 7 : 6;
      else if ({r, c, w} == 3'b011) pat = 8;
      else if ({r, c, w} == 3'b100) pat = a10 ? 10 : 9;
      else if ({r, c, w} == 3'b101) pat = a10 ? 12 : 11;
      else pat = 15;
      idle = (pat <= 1);
      nst = m_state;
      if (m_state != 0) begin
         if (k) begin
            code = idle ? (m_state == 2 ? 5 : 14) : 15;
            if (idle) nst = 0;
         end else code = idle ? pat : 15;
      end else if (m_prev == 1 && k) code = pat;
      else if (m_prev == 1 && !k) begin
         if (idle) begin code = 13; nst = 1; end
         else if (pat == 3) begin code = 4; nst = 2; end
         else code = 15;
      end else code = idle ? (k ? 14 : pat) : 15;
      eb = 0; ea = 0; ef = 0;
      if (code == 2 || code == 8) begin eb = b; ea = a; end
      else if (code == 6) eb = b;
      else if (code == 7) ef = 1;
      else if (code >= 9 && code <= 12) begin
         eb = b; ea = a & ~(1 << A10); ef = (code == 10 || code == 12);
      end
      col = (code >= 9 && code <= 12);
      err = col && (m_cnt > 0);
      if (col && !err) m_cnt = BC - 1;
      else if (m_cnt > 0) m_cnt--;
      m_prev = k; m_state = nst;
      @(posedge clk); @(negedge clk);
      check_all(tag, code, eb, ea, ef, code == 15, err, m_cnt > 0, m_state);
   endtask

   initial begin
      #(20 * 5000);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_all("R1", 0, 0, 0, 0, 0, 0, 0, 0);
      rst_n = 1'b1;
      // first high edge after reset counts as an exit (R6)
      step("R6", 1, 0, 1, 1, 1, 0, 0);
      step("R3", 1, 0, 0, 0, 0, 2, 'h0433);      // MRS
      step("R3", 1, 0, 0, 1, 1, 1, 'h1abc);      // ACT
      step("R5", 1, 0, 1, 0, 0, 1, 'h0408);      // WRA
      step("R9", 1, 0, 1, 0, 1, 3, 'h0010);      // RD inside burst
      step("R9", 1, 0, 1, 1, 1, 0, 0);
      step("R5", 1, 0, 1, 0, 1, 3, 'h0010);      // RD
      step("R9", 1, 0, 1, 1, 1, 0, 0);           // one gap
      step("R5", 1, 0, 1, 0, 0, 5, 'h83f0);      // WR
      step("R9", 1, 1, 1, 1, 1, 0, 0);
      step("R5", 1, 0, 1, 0, 1, 6, 'h07ff);      // RDA
      step("R10", 1, 0, 1, 1, 1, 0, 0);
      step("R3", 1, 1, 0, 0, 0, 7, 'hffff);      // deselect ignores pins
      step("R4", 1, 0, 0, 1, 0, 2, 'h0000);      // PRE bank 2
      step("R4", 1, 0, 0, 1, 0, 5, 'h0400);      // PREA
      step("R3", 1, 0, 0, 0, 1, 0, 0);           // REF
      step("R8", 1, 0, 1, 1, 0, 0, 0);           // undefined pattern
      step("R6", 0, 0, 1, 1, 1, 0, 0);           // PDE
      step("R8", 0, 0, 0, 1, 1, 1, 'h0123);      // ACT in power-down
      step("R6", 0, 1, 0, 0, 0, 0, 0);           // deselect stays
      step("R6", 1, 0, 1, 1, 1, 0, 0);           // PDX
      step("R7", 0, 0, 0, 0, 1, 0, 0);           // SRE
      step("R7", 0, 0, 1, 1, 1, 0, 0);
      step("R8", 1, 0, 1, 0, 1, 0, 0);           // read at exit attempt
      step("R7", 1, 1, 1, 1, 1, 0, 0);           // SRX
      step("R8", 0, 0, 0, 1, 1, 0, 0);           // ACT with CKE falling
      step("R8", 1, 0, 1, 1, 1, 0, 0);
      step("R3", 1, 0, 1, 1, 1, 0, 0);           // NOP
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule